// File: doc/BRIEF.md
# Micro-op Loop GEMM Sequencer

This block executes one matrix-multiply instruction by replaying a window of micro-ops held in a local micro-op memory. The window runs from a begin address up to, but not including, an end address, and is played back inside two nested hardware loops. The micro-op loop is the innermost, then the inner iteration loop, then the outer iteration loop. Each micro-op word supplies base indices into the accumulator, input and weight buffers. The sequencer adds a per-loop affine offset to each base index and issues the resulting index triple to a dot-product datapath. That datapath adds the dot product of the addressed input and weight vectors into the addressed accumulator entry, or clears that entry when the instruction's clear flag is set.

A controller presents the decoded instruction fields together with a one-cycle `start` pulse. The sequencer latches the fields, reads micro-ops through a synchronous read port, and hands out one triple per cycle under a valid/ready handshake. It pulses `done` once the last triple has been accepted. The buffers and the arithmetic sit outside the block.

Top module: `gemm_uop_sequencer`

## Requirements
- R1: For each pass over the window, the micro-op memory is read at addresses `uop_bgn`, `uop_bgn+1`, … up to `uop_end-1`, in increasing order. `uop_end` is one bit wider than `uop_bgn`, so a window can reach the last entry of the memory. The read port has one cycle of latency, and its data holds while `uop_rd_en` is low.
- R2: The window is replayed `iter_in` times for each of `iter_out` outer iterations, with the micro-op loop innermost. An instruction issues exactly (uop_end−uop_bgn)·iter_in·iter_out triples, in that nesting order.
- R3: In a micro-op word, the accumulator index sits in bits [ACC_AW-1:0]. The input index occupies the next INP_AW bits, and the weight index the WGT_AW bits above those.
- R4: Each issued index equals its micro-op base + outer_count·factor_out + inner_count·factor_in, taken modulo its buffer depth (2^width). Each of the three indices has its own pair of factors.
- R5: `op_clear` equals the instruction's clear flag on every triple of that instruction.
- R6: When `uop_bgn` ≥ `uop_end`, or when `iter_in` or `iter_out` is zero, `done` is high in the cycle after `start`. No memory read and no triple occur.
- R7: A triple with `op_valid` high and `op_ready` low stays valid with all its fields unchanged. While `op_ready` is held high, triples are accepted on consecutive cycles.
- R8: A `start` pulse while an instruction is running is ignored. Instruction inputs are latched at start, and later changes to them have no effect on the running instruction.
- R9: `done` is a single-cycle pulse. It is high in the cycle after the last triple is accepted, and it pulses once per instruction.
- R10: After reset, `op_valid`, `done` and `uop_rd_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse for the presented instruction |
| uop_bgn | input | UOP_AW | First micro-op address of the window |
| uop_end | input | UOP_AW+1 | One past the last micro-op address |
| iter_out | input | ITER_W | Outer loop count |
| iter_in | input | ITER_W | Inner loop count |
| acc_f_out | input | ACC_AW | Accumulator index outer factor |
| acc_f_in | input | ACC_AW | Accumulator index inner factor |
| inp_f_out | input | INP_AW | Input index outer factor |
| inp_f_in | input | INP_AW | Input index inner factor |
| wgt_f_out | input | WGT_AW | Weight index outer factor |
| wgt_f_in | input | WGT_AW | Weight index inner factor |
| clear_acc | input | 1 | Clear addressed accumulator entries instead of accumulating |
| uop_rd_en | output | 1 | Micro-op memory read enable |
| uop_rd_addr | output | UOP_AW | Micro-op memory read address |
| uop_rd_data | input | ACC_AW+INP_AW+WGT_AW | Micro-op word, valid one cycle after the read |
| op_valid | output | 1 | Index triple valid |
| op_ready | input | 1 | Datapath accepts the triple |
| op_acc_idx | output | ACC_AW | Accumulator index |
| op_inp_idx | output | INP_AW | Input buffer index |
| op_wgt_idx | output | WGT_AW | Weight buffer index |
| op_clear | output | 1 | Clear instead of accumulate |
| done | output | 1 | Instruction complete pulse |

## Verification
The bench builds the block with ACC_AW=4, INP_AW=3, WGT_AW=3, UOP_AW=3 and ITER_W=3. With these widths the micro-op memory has eight entries, so a window ending at address 8 exercises the extra top bit of `uop_end`. Factors of up to 15 make all three indices wrap within a few iterations. Iteration counts up to 7 keep every nested replay short enough to compare triple by triple against a bench-side model, under both a steady and a pseudo-random ready pattern.

// File: rtl/uopseq_pkg.sv
package uopseq_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_GEN   = 2'd1,
    SQ_DRAIN = 2'd2
  } seq_state_e;
endpackage

// File: rtl/uop_loop_nest.sv
module uop_loop_nest #(
  parameter int UOP_AW = 13,
  parameter int ITER_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  input  logic [UOP_AW-1:0] bgn,
  input  logic [UOP_AW:0]   fin,
  input  logic [ITER_W-1:0] n_in,
  input  logic [ITER_W-1:0] n_out,
  input  logic              issue,
  output logic [UOP_AW-1:0] rd_addr,
  output logic              running,
  output logic              step_in,
  output logic              step_out,
  output logic              last_issue
);
  localparam logic [UOP_AW:0]   K_ONE = {{UOP_AW{1'b0}}, 1'b1};
  localparam logic [ITER_W-1:0] I_ONE = {{(ITER_W-1){1'b0}}, 1'b1};

  logic [UOP_AW:0]   k_q, end_q, bgn_q;
  logic [ITER_W-1:0] inner_q, outer_q, nin_q, nout_q;
  logic              run_q;
  logic              k_last, in_last, out_last;

  assign k_last   = (k_q + K_ONE) == end_q;
  assign in_last  = inner_q == (nin_q - I_ONE);
  assign out_last = outer_q == (nout_q - I_ONE);

  assign step_in    = issue && k_last && !in_last;
  assign step_out   = issue && k_last && in_last && !out_last;
  assign last_issue = issue && k_last && in_last && out_last;
  assign rd_addr    = k_q[UOP_AW-1:0];
  assign running    = run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      k_q     <= '0;
      bgn_q   <= '0;
      end_q   <= '0;
      nin_q   <= '0;
      nout_q  <= '0;
      inner_q <= '0;
      outer_q <= '0;
      run_q   <= 1'b0;
    end else if (launch) begin
      k_q     <= {1'b0, bgn};
      bgn_q   <= {1'b0, bgn};
      end_q   <= fin;
      nin_q   <= n_in;
      nout_q  <= n_out;
      inner_q <= '0;
      outer_q <= '0;
      run_q   <= 1'b1;
    end else if (issue) begin
      if (k_last) begin
        k_q <= bgn_q;
        if (in_last) begin
          inner_q <= '0;
          if (out_last) run_q <= 1'b0;
          else          outer_q <= outer_q + I_ONE;
        end else begin
          inner_q <= inner_q + I_ONE;
        end
      end else begin
        k_q <= k_q + K_ONE;
      end
    end
  end

  // R1: the read pointer never leaves the latched window
  p_addr_window_r1: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (k_q >= bgn_q) && (k_q < end_q));

  // R2: loop counters stay below their latched trip counts
  p_counter_bound_r2: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (inner_q < nin_q) && (outer_q < nout_q));
endmodule

// File: rtl/affine_lane.sv
module affine_lane #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         launch,
  input  logic [W-1:0] f_in,
  input  logic [W-1:0] f_out,
  input  logic         step_in,
  input  logic         step_out,
  input  logic         capture,
  input  logic         load,
  input  logic [W-1:0] base,
  output logic [W-1:0] idx
);
  logic [W-1:0] fin_q, fout_q, off_in_q, off_out_q, sum_q, idx_q;

  assign idx = idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fin_q     <= '0;
      fout_q    <= '0;
      off_in_q  <= '0;
      off_out_q <= '0;
    end else if (launch) begin
      fin_q     <= f_in;
      fout_q    <= f_out;
      off_in_q  <= '0;
      off_out_q <= '0;
    end else if (step_out) begin
      off_in_q  <= '0;
      off_out_q <= off_out_q + fout_q;
    end else if (step_in) begin
      off_in_q  <= off_in_q + fin_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q <= '0;
      idx_q <= '0;
    end else begin
      if (capture) sum_q <= off_out_q + off_in_q;
      if (load)    idx_q <= base + sum_q;
    end
  end
endmodule

// File: rtl/gemm_uop_sequencer.sv
module gemm_uop_sequencer
  import uopseq_pkg::*;
#(
  parameter int ACC_AW = 11,
  parameter int INP_AW = 11,
  parameter int WGT_AW = 10,
  parameter int UOP_AW = 13,
  parameter int ITER_W = 14
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             start,
  input  logic [UOP_AW-1:0]                uop_bgn,
  input  logic [UOP_AW:0]                  uop_end,
  input  logic [ITER_W-1:0]                iter_out,
  input  logic [ITER_W-1:0]                iter_in,
  input  logic [ACC_AW-1:0]                acc_f_out,
  input  logic [ACC_AW-1:0]                acc_f_in,
  input  logic [INP_AW-1:0]                inp_f_out,
  input  logic [INP_AW-1:0]                inp_f_in,
  input  logic [WGT_AW-1:0]                wgt_f_out,
  input  logic [WGT_AW-1:0]                wgt_f_in,
  input  logic                             clear_acc,
  output logic                             uop_rd_en,
  output logic [UOP_AW-1:0]                uop_rd_addr,
  input  logic [ACC_AW+INP_AW+WGT_AW-1:0]  uop_rd_data,
  output logic                             op_valid,
  input  logic                             op_ready,
  output logic [ACC_AW-1:0]                op_acc_idx,
  output logic [INP_AW-1:0]                op_inp_idx,
  output logic [WGT_AW-1:0]                op_wgt_idx,
  output logic                             op_clear,
  output logic                             done
);
  localparam int INP_LSB = ACC_AW;
  localparam int WGT_LSB = ACC_AW + INP_AW;

  seq_state_e state_q;
  logic pend_q, valid_q, clear_q, clr_lat_q, done_q;
  logic empty, accept, launch, out_free, take, issue;
  logic running, step_in, step_out, last_issue;

  assign empty    = ({1'b0, uop_bgn} >= uop_end) || (iter_in == '0) || (iter_out == '0);
  assign accept   = start && (state_q == SQ_IDLE);
  assign launch   = accept && !empty;
  assign out_free = !valid_q || op_ready;
  assign take     = pend_q && out_free;
  assign issue    = running && (!pend_q || take);

  assign uop_rd_en = issue;
  assign op_valid  = valid_q;
  assign op_clear  = clear_q;
  assign done      = done_q;

  uop_loop_nest #(.UOP_AW(UOP_AW), .ITER_W(ITER_W)) u_nest (
    .clk(clk), .rst(rst), .launch(launch),
    .bgn(uop_bgn), .fin(uop_end), .n_in(iter_in), .n_out(iter_out),
    .issue(issue), .rd_addr(uop_rd_addr), .running(running),
    .step_in(step_in), .step_out(step_out), .last_issue(last_issue)
  );

  affine_lane #(.W(ACC_AW)) u_acc_lane (
    .clk(clk), .rst(rst), .launch(launch), .f_in(acc_f_in), .f_out(acc_f_out),
    .step_in(step_in), .step_out(step_out), .capture(issue), .load(take),
    .base(uop_rd_data[ACC_AW-1:0]), .idx(op_acc_idx)
  );

  affine_lane #(.W(INP_AW)) u_inp_lane (
    .clk(clk), .rst(rst), .launch(launch), .f_in(inp_f_in), .f_out(inp_f_out),
    .step_in(step_in), .step_out(step_out), .capture(issue), .load(take),
    .base(uop_rd_data[INP_LSB +: INP_AW]), .idx(op_inp_idx)
  );

  affine_lane #(.W(WGT_AW)) u_wgt_lane (
    .clk(clk), .rst(rst), .launch(launch), .f_in(wgt_f_in), .f_out(wgt_f_out),
    .step_in(step_in), .step_out(step_out), .capture(issue), .load(take),
    .base(uop_rd_data[WGT_LSB +: WGT_AW]), .idx(op_wgt_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= SQ_IDLE;
      pend_q    <= 1'b0;
      valid_q   <= 1'b0;
      clear_q   <= 1'b0;
      clr_lat_q <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (launch) clr_lat_q <= clear_acc;
      if (issue)     pend_q <= 1'b1;
      else if (take) pend_q <= 1'b0;
      if (take) begin
        valid_q <= 1'b1;
        clear_q <= clr_lat_q;
      end else if (op_ready) begin
        valid_q <= 1'b0;
      end
      case (state_q)
        SQ_IDLE: begin
          if (launch) state_q <= SQ_GEN;
          if (accept && empty) done_q <= 1'b1;
        end
        SQ_GEN: if (last_issue) state_q <= SQ_DRAIN;
        SQ_DRAIN: begin
          if (!pend_q && out_free) begin
            state_q <= SQ_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  // R7: a stalled triple holds its value
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !op_ready) |=> (op_valid && $stable(op_acc_idx) &&
      $stable(op_inp_idx) && $stable(op_wgt_idx) && $stable(op_clear)));

  // R1: a fetched word waiting for a stalled slot is never overwritten by a new read
  p_no_overrun_r1: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !out_free) |-> !uop_rd_en);

  // R9: done lasts one cycle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6: no memory traffic while idle
  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (state_q == SQ_IDLE) |-> !uop_rd_en);
endmodule

// File: tb/test_gemm_uop_sequencer.sv
module test_gemm_uop_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int ACC_AW = 4, INP_AW = 3, WGT_AW = 3, UOP_AW = 3, ITER_W = 3;
  localparam int UW = ACC_AW + INP_AW + WGT_AW;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [UOP_AW-1:0] uop_bgn = '0;
  logic [UOP_AW:0]   uop_end = '0;
  logic [ITER_W-1:0] iter_out = '0, iter_in = '0;
  logic [ACC_AW-1:0] acc_f_out = '0, acc_f_in = '0;
  logic [INP_AW-1:0] inp_f_out = '0, inp_f_in = '0;
  logic [WGT_AW-1:0] wgt_f_out = '0, wgt_f_in = '0;
  logic clear_acc = 1'b0;
  logic uop_rd_en;
  logic [UOP_AW-1:0] uop_rd_addr;
  logic [UW-1:0] uop_rd_data = '0;
  logic op_valid, op_ready = 1'b1, op_clear, done;
  logic [ACC_AW-1:0] op_acc_idx;
  logic [INP_AW-1:0] op_inp_idx;
  logic [WGT_AW-1:0] op_wgt_idx;

  gemm_uop_sequencer #(.ACC_AW(ACC_AW), .INP_AW(INP_AW), .WGT_AW(WGT_AW),
    .UOP_AW(UOP_AW), .ITER_W(ITER_W)) i_gemm_uop_sequencer (
    .clk(clk), .rst(rst), .start(start), .uop_bgn(uop_bgn), .uop_end(uop_end),
    .iter_out(iter_out), .iter_in(iter_in), .acc_f_out(acc_f_out), .acc_f_in(acc_f_in),
    .inp_f_out(inp_f_out), .inp_f_in(inp_f_in), .wgt_f_out(wgt_f_out), .wgt_f_in(wgt_f_in),
    .clear_acc(clear_acc), .uop_rd_en(uop_rd_en), .uop_rd_addr(uop_rd_addr),
    .uop_rd_data(uop_rd_data), .op_valid(op_valid), .op_ready(op_ready),
    .op_acc_idx(op_acc_idx), .op_inp_idx(op_inp_idx), .op_wgt_idx(op_wgt_idx),
    .op_clear(op_clear), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [UW-1:0] umem [8];
  always_ff @(posedge clk) if (uop_rd_en) uop_rd_data <= umem[uop_rd_addr];

  int total = 0, fails = 0, cyc = 0;
  int exp_acc [1024], exp_inp [1024], exp_wgt [1024];
  int exp_n = 0, exp_ptr = 0, exp_clr = 0;
  int first_hs = -1, last_hs = -1, done_cnt = 0, done_cyc = -1, rd_cnt = 0;
  int ready_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit hold_v = 0;
  int h_val = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    op_ready = (ready_mode == 0) ? 1'b1 : lfsr[0];
  end

  always @(negedge clk) if (!rst) begin
    if (hold_v)
      chk(op_valid && (h_val == {op_clear, op_acc_idx, op_inp_idx, op_wgt_idx}),
          "R7", "stalled triple changed", {op_clear, op_acc_idx, op_inp_idx, op_wgt_idx}, h_val);
    hold_v = op_valid && !op_ready;
    h_val  = {op_clear, op_acc_idx, op_inp_idx, op_wgt_idx};
    if (uop_rd_en) rd_cnt++;
    if (op_valid && op_ready) begin
      if (exp_ptr < exp_n) begin
        chk(op_acc_idx == exp_acc[exp_ptr], "R4", "acc index", op_acc_idx, exp_acc[exp_ptr]);
        chk(op_inp_idx == exp_inp[exp_ptr], "R3", "inp index", op_inp_idx, exp_inp[exp_ptr]);
        chk(op_wgt_idx == exp_wgt[exp_ptr], "R1", "wgt index", op_wgt_idx, exp_wgt[exp_ptr]);
        chk(op_clear == exp_clr[0], "R5", "clear flag", op_clear, exp_clr);
      end else begin
        chk(1'b0, "R2", "extra triple", exp_ptr + 1, exp_n);
      end
      if (first_hs < 0) first_hs = cyc;
      last_hs = cyc;
      exp_ptr++;
    end
    if (done) begin
      done_cnt++;
      done_cyc = cyc;
    end
  end

  task automatic pulse_start();
    @(posedge clk); #2 start = 1'b1;
    @(posedge clk); #2 start = 1'b0;
  endtask

  task automatic set_instr(input int b, input int e, input int ni, input int no,
                           input int af0, input int af1, input int if0, input int if1,
                           input int wf0, input int wf1, input bit clr);
    uop_bgn = UOP_AW'(b); uop_end = (UOP_AW+1)'(e);
    iter_in = ITER_W'(ni); iter_out = ITER_W'(no);
    acc_f_out = ACC_AW'(af0); acc_f_in = ACC_AW'(af1);
    inp_f_out = INP_AW'(if0); inp_f_in = INP_AW'(if1);
    wgt_f_out = WGT_AW'(wf0); wgt_f_in = WGT_AW'(wf1);
    clear_acc = clr;
  endtask

  // Expected stream from the nested-loop definition
  task automatic build_expected();
    exp_n = 0;
    for (int o = 0; o < int'(iter_out); o++)
      for (int i = 0; i < int'(iter_in); i++)
        for (int k = int'(uop_bgn); k < int'(uop_end); k++) begin
          exp_acc[exp_n] = (int'(umem[k][3:0]) + o*int'(acc_f_out) + i*int'(acc_f_in)) % 16;
          exp_inp[exp_n] = (int'(umem[k][6:4]) + o*int'(inp_f_out) + i*int'(inp_f_in)) % 8;
          exp_wgt[exp_n] = (int'(umem[k][9:7]) + o*int'(wgt_f_out) + i*int'(wgt_f_in)) % 8;
          exp_n++;
        end
    exp_clr = clear_acc;
    exp_ptr = 0; first_hs = -1; last_hs = -1; done_cnt = 0; done_cyc = -1; rd_cnt = 0;
  endtask

  task automatic finish_run(input string name, input int mode);
    int t;
    t = 0;
    while (done_cnt == 0 && t < 3000) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
    chk(done_cnt == 1, "R9", {name, " done pulses"}, done_cnt, 1);
    chk(exp_ptr == exp_n, "R2", {name, " triple count"}, exp_ptr, exp_n);
    chk(done_cyc == last_hs + 1, "R9", {name, " done timing"}, done_cyc, last_hs + 1);
    if (mode == 0)
      chk(last_hs - first_hs == exp_n - 1, "R7", {name, " back-to-back"}, last_hs - first_hs, exp_n - 1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!op_valid, "R10", "valid after reset", op_valid, 0);
    chk(!done, "R10", "done after reset", done, 0);
    chk(!uop_rd_en, "R10", "read after reset", uop_rd_en, 0);
  endtask

  task automatic t_basic();  // R1 R2 R4
    ready_mode = 0;
    set_instr(2, 5, 3, 2, 3, 5, 1, 2, 3, 1, 1'b0);
    build_expected(); pulse_start(); finish_run("basic", 0);
  endtask

  task automatic t_full_window_stall();  // R1 end=8 uses top bit, R7 under stalls
    ready_mode = 1;
    set_instr(0, 8, 2, 3, 7, 9, 5, 3, 6, 2, 1'b0);
    build_expected(); pulse_start(); finish_run("full window stalled", 1);
    ready_mode = 0;
  endtask

  task automatic t_wrap();  // R4 modulo wrap
    ready_mode = 0;
    set_instr(6, 8, 7, 5, 15, 13, 7, 6, 5, 7, 1'b0);
    build_expected(); pulse_start(); finish_run("wrap", 0);
  endtask

  task automatic t_clear();  // R5
    ready_mode = 1;
    set_instr(1, 3, 2, 2, 1, 4, 2, 3, 1, 1, 1'b1);
    build_expected(); pulse_start(); finish_run("clear", 1);
    ready_mode = 0;
  endtask

  task automatic t_empty(input string name, input int b, input int e, input int ni, input int no);  // R6
    set_instr(b, e, ni, no, 1, 1, 1, 1, 1, 1, 1'b0);
    build_expected();
    exp_n = 0;
    pulse_start();
    @(negedge clk);
    chk(done == 1'b1, "R6", {name, " done next cycle"}, done, 1);
    @(negedge clk);
    chk(done == 1'b0, "R9", {name, " done single"}, done, 0);
    repeat (3) @(negedge clk);
    chk(rd_cnt == 0, "R6", {name, " reads"}, rd_cnt, 0);
    chk(exp_ptr == 0, "R6", {name, " triples"}, exp_ptr, 0);
  endtask

  task automatic t_busy();  // R8
    ready_mode = 1;
    set_instr(3, 7, 3, 3, 2, 3, 1, 1, 2, 3, 1'b0);
    build_expected(); pulse_start();
    repeat (4) @(posedge clk);
    set_instr(4, 4, 1, 1, 9, 9, 5, 5, 5, 5, 1'b1);
    pulse_start();
    finish_run("start while busy", 1);
    ready_mode = 0;
  endtask

  initial begin
    for (int k = 0; k < 8; k++)
      umem[k] = UW'(((k*7 + 3) % 8) << 7 | ((k*5 + 2) % 8) << 4 | ((k*3 + 1) % 16));
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    t_reset();
    t_basic();
    t_full_window_stall();
    t_wrap();
    t_clear();
    t_empty("bgn equals end", 5, 5, 2, 2);
    t_empty("bgn above end", 6, 3, 2, 2);
    t_empty("zero inner", 0, 4, 0, 2);
    t_empty("zero outer", 0, 4, 2, 0);
    t_busy();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R9", "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule